// File: doc/BRIEF.md
# Per-Pin Selectable Input Debouncer

This block filters a group of 32 general-purpose inputs, organised as four banks of eight pins. Every raw input is first brought into the local clock domain by a two-stage synchronizer. Each pin then either passes its synchronized level straight through, or holds its filtered level until the synchronized input has kept a new level for a programmed number of clock cycles.

Three period registers are shared by the whole group. Each pin picks one of them, or no filtering, with a 2-bit mode code. The two code bits of a pin sit in two separate select registers: one register holds the high code bit of every pin and the other holds the low code bit. Software loads all five registers through a single-cycle write strobe. Periods are counted in cycles of the block clock, which is usually a slow peripheral clock.

Top module: `pin_debounce_top`

## Requirements
- R1: While reset is low and directly after it, every configuration register reads zero and every filtered output is low, because the synchronizer stages are cleared too.
- R2: In bypass the filtered output shows a raw input change after exactly two rising clock edges, counting the first edge after the change.
- R3: A write to address 3 loads the high mode bit of pin i from wr_data[i]. A write to address 4 loads the low mode bit. Code 00 is bypass, and codes 01, 10 and 11 select the periods written at addresses 0, 1 and 2. A period uses wr_data[15:0].
- R4: In a filtered mode with period T > 0, a steady new raw level reaches the output after exactly T+2 rising edges, counting the first edge after the change.
- R5: If the synchronized input goes back to the filtered level before the period has elapsed, the count restarts. The output then changes T+2 edges after the input last settled at the new level.
- R6: A pin whose selected period register holds zero behaves exactly as bypass (R2 latency).
- R7: A change of a pin's mode or of its selected period value clears that pin's count. After a period write lands at edge w, the pending change appears T_new+2 edges after edge w, counting edge w as 1.
- R8: Falling transitions are filtered with the same latency as rising ones.
- R9: Writes to addresses 5, 6 and 7 change no register and have no effect on any pin's filtering.
- R10: Each pin's latency depends only on its own mode code. Pins in different modes switched at the same moment each keep their own timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; periods count its cycles |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Single-cycle register write strobe |
| wr_addr | input | 3 | Register address (0..2 periods, 3 high mode bits, 4 low mode bits) |
| wr_data | input | 32 | Write data |
| pin_raw | input | 32 | Asynchronous raw pin levels |
| pin_filt | output | 32 | Filtered pin levels |

## Verification
Each sweep switches all 32 pins together and measures, edge by edge, the exact cycle in which each pin flips. A design off by one in the synchronizer or the counter compare fails every pin, and a design that swaps the two select registers puts half the pins on the wrong period. A short dip in the input during filtering catches a counter that only pauses instead of restarting, because such a design flips the output several cycles early. A period rewrite in the middle of a count catches a counter that is not cleared: with the smaller new period, such a design fires almost at once. Writes to the unused addresses with all-ones data expose address aliasing, which would shift the latency of every pin.

// File: rtl/pindeb_pkg.sv
// Shared constants and types for the per-pin debouncer.
// Assumes a fixed 3-bit register address space.
package pindeb_pkg;
    localparam int REG_AW = 3;

    localparam logic [REG_AW-1:0] ADR_PER1  = 3'd0;
    localparam logic [REG_AW-1:0] ADR_PER2  = 3'd1;
    localparam logic [REG_AW-1:0] ADR_PER3  = 3'd2;
    localparam logic [REG_AW-1:0] ADR_SELHI = 3'd3;
    localparam logic [REG_AW-1:0] ADR_SELLO = 3'd4;

    localparam int NUM_PER = 3;

    typedef enum logic [1:0] {
        DB_BYPASS = 2'b00,
        DB_PER1   = 2'b01,
        DB_PER2   = 2'b10,
        DB_PER3   = 2'b11
    } db_mode_t;
endpackage

// File: rtl/deb_regs.sv
// Register file: three shared period registers and the two mode-select
// registers. Assumes DATA_W >= NUM_PINS and DATA_W >= PER_W; writes to
// addresses outside the decoded set are dropped.
module deb_regs
    import pindeb_pkg::*;
#(
    parameter int NUM_PINS = 32,
    parameter int PER_W    = 16,
    parameter int DATA_W   = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [REG_AW-1:0]          wr_addr,
    input  logic [DATA_W-1:0]          wr_data,
    output logic [NUM_PINS-1:0]        sel_hi,
    output logic [NUM_PINS-1:0]        sel_lo,
    output logic [NUM_PER*PER_W-1:0]   per_flat
);
    logic [PER_W-1:0] per_q [NUM_PER];

    // Mode-select registers: load on a matching write, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_hi <= '0;
            sel_lo <= '0;
        end else if (wr_en) begin
            if (wr_addr == ADR_SELHI) sel_hi <= wr_data[NUM_PINS-1:0];
            if (wr_addr == ADR_SELLO) sel_lo <= wr_data[NUM_PINS-1:0];
        end
    end

    for (genvar k = 0; k < NUM_PER; k++) begin : g_per
        localparam logic [REG_AW-1:0] MY_ADR = ADR_PER1 + REG_AW'(k);

        // Period register k: load on its own address, clear on reset.
        always_ff @(posedge clk) begin
            if (!rst_n)
                per_q[k] <= '0;
            else if (wr_en && wr_addr == MY_ADR)
                per_q[k] <= wr_data[PER_W-1:0];
        end

        assign per_flat[k*PER_W +: PER_W] = per_q[k];
    end
endmodule

// File: rtl/deb_sync.sv
// Two-stage synchronizer for a vector of asynchronous inputs.
// Assumes each bit is independent; both stages clear on reset.
module deb_sync #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] meta_q;

    // Shift the raw levels through two flop stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            q_sync <= '0;
        end else begin
            meta_q <= d_async;
            q_sync <= meta_q;
        end
    end
endmodule

// File: rtl/deb_cell.sv
// One pin's stability filter. In bypass (mode 00 or a zero period) the
// output is the synchronized level. Otherwise the held level moves to the
// input only after `limit` consecutive edges at the new level. Any mismatch
// loss, mode change or period change restarts the count.
module deb_cell
    import pindeb_pkg::*;
#(
    parameter int PER_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_in,
    input  db_mode_t         mode,
    input  logic [PER_W-1:0] limit,
    output logic             filt
);
    logic             held_q;
    logic [PER_W-1:0] cnt_q;
    db_mode_t         mode_q;
    logic [PER_W-1:0] limit_q;
    logic             bypass;
    logic             cfg_chg;
    logic [PER_W:0]   cnt_nxt;

    assign bypass  = (mode == DB_BYPASS) || (limit == '0);
    assign cfg_chg = (mode != mode_q) || (limit != limit_q);
    assign cnt_nxt = {1'b0, cnt_q} + 1'b1;

    // Remember the last configuration seen, to detect changes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= DB_BYPASS;
            limit_q <= '0;
        end else begin
            mode_q  <= mode;
            limit_q <= limit;
        end
    end

    // Stability counter and held level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= 1'b0;
            cnt_q  <= '0;
        end else if (bypass) begin
            held_q <= sync_in;
            cnt_q  <= '0;
        end else if (sync_in == held_q || cfg_chg) begin
            cnt_q  <= '0;
        end else if (cnt_nxt >= {1'b0, limit}) begin
            held_q <= sync_in;
            cnt_q  <= '0;
        end else begin
            cnt_q  <= cnt_nxt[PER_W-1:0];
        end
    end

    assign filt = bypass ? sync_in : held_q;
endmodule

// File: rtl/pin_debounce_top.sv
// Debouncer for BANKS x BANK_PINS general-purpose inputs. Each pin takes its
// mode code as {sel_hi[i], sel_lo[i]} and a period from the shared registers.
// Assumes a single clock and a synchronous active-low reset.
module pin_debounce_top
    import pindeb_pkg::*;
#(
    parameter int BANKS     = 4,
    parameter int BANK_PINS = 8,
    parameter int PER_W     = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [REG_AW-1:0]          wr_addr,
    input  logic [BANKS*BANK_PINS-1:0] wr_data,
    input  logic [BANKS*BANK_PINS-1:0] pin_raw,
    output logic [BANKS*BANK_PINS-1:0] pin_filt
);
    localparam int NUM_PINS = BANKS * BANK_PINS;

    logic [NUM_PINS-1:0]      sel_hi;
    logic [NUM_PINS-1:0]      sel_lo;
    logic [NUM_PER*PER_W-1:0] per_flat;
    logic [NUM_PINS-1:0]      sync_q;

    deb_regs #(
        .NUM_PINS (NUM_PINS),
        .PER_W    (PER_W),
        .DATA_W   (NUM_PINS)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .sel_hi   (sel_hi),
        .sel_lo   (sel_lo),
        .per_flat (per_flat)
    );

    deb_sync #(.WIDTH(NUM_PINS)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (pin_raw),
        .q_sync  (sync_q)
    );

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        db_mode_t         mode;
        logic [PER_W-1:0] limit;

        assign mode = db_mode_t'({sel_hi[i], sel_lo[i]});

        // Pick the shared period addressed by this pin's mode code.
        always_comb begin
            unique case (mode)
                DB_PER1: limit = per_flat[0*PER_W +: PER_W];
                DB_PER2: limit = per_flat[1*PER_W +: PER_W];
                DB_PER3: limit = per_flat[2*PER_W +: PER_W];
                default: limit = '0;
            endcase
        end

        deb_cell #(.PER_W(PER_W)) u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .sync_in (sync_q[i]),
            .mode    (mode),
            .limit   (limit),
            .filt    (pin_filt[i])
        );
    end
endmodule

// File: rtl/pin_debounce_chk.sv
// Assertion checker for pin_debounce_top, attached by bind below.
// It observes the register state, the synchronizer output and the pins.
module pin_debounce_chk
    import pindeb_pkg::*;
#(
    parameter int NUM_PINS = 32,
    parameter int PER_W    = 16
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     wr_en,
    input logic [REG_AW-1:0]        wr_addr,
    input logic [NUM_PINS-1:0]      wr_data,
    input logic [NUM_PINS-1:0]      sel_hi,
    input logic [NUM_PINS-1:0]      sel_lo,
    input logic [NUM_PER*PER_W-1:0] per_flat,
    input logic [NUM_PINS-1:0]      sync_q,
    input logic [NUM_PINS-1:0]      pin_filt
);
    // R3
    selhi_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADR_SELHI) |=> sel_hi == $past(wr_data));

    // R3
    per3_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADR_PER3) |=> per_flat[2*PER_W +: PER_W] == $past(wr_data[PER_W-1:0]));

    // R9
    unused_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr > ADR_SELLO) |=> ($stable(sel_hi) && $stable(sel_lo) && $stable(per_flat)));

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        logic [1:0]       code;
        logic [PER_W-1:0] per;
        logic             byp;

        assign code = {sel_hi[i], sel_lo[i]};

        // Period this pin is meant to use.
        always_comb begin
            case (code)
                2'b01:   per = per_flat[0*PER_W +: PER_W];
                2'b10:   per = per_flat[1*PER_W +: PER_W];
                2'b11:   per = per_flat[2*PER_W +: PER_W];
                default: per = '0;
            endcase
        end
        assign byp = (code == 2'b00) || (per == '0);

        // R6
        bypass_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            byp |-> pin_filt[i] == sync_q[i]);

        // R4
        settled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!byp && sync_q[i] == pin_filt[i]) |=> (byp || $stable(pin_filt[i])));

        // R4
        move_to_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!byp && $past(!byp) && !$stable(pin_filt[i])) |-> pin_filt[i] == $past(sync_q[i]));
    end
endmodule

bind pin_debounce_top pin_debounce_chk #(
    .NUM_PINS (BANKS * BANK_PINS),
    .PER_W    (PER_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .sel_hi   (sel_hi),
    .sel_lo   (sel_lo),
    .per_flat (per_flat),
    .sync_q   (sync_q),
    .pin_filt (pin_filt)
);

// File: tb/pin_debounce_top_bench.sv
module pin_debounce_top_bench;
    localparam int NP   = 32;
    localparam int MAXW = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [2:0]    wr_addr = '0;
    logic [NP-1:0] wr_data = '0;
    logic [NP-1:0] pin_raw = '0;
    logic [NP-1:0] pin_filt;

    int errors = 0;
    int checks = 0;
    int per_m [3] = '{0, 0, 0};
    logic [NP-1:0] hi_m = '0;
    logic [NP-1:0] lo_m = '0;

    always #4 clk = ~clk;

    pin_debounce_top u_pin_debounce_top (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .pin_raw  (pin_raw),
        .pin_filt (pin_filt)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_lat(input int p);
        int m;
        m = {hi_m[p], lo_m[p]};
        if (m == 0 || per_m[m-1] == 0) return 2;
        return per_m[m-1] + 2;
    endfunction

    task automatic wr(input logic [2:0] a, input logic [NP-1:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
        if (a <= 3'd2) per_m[a] = int'(d[15:0]);
        if (a == 3'd3) hi_m = d;
        if (a == 3'd4) lo_m = d;
    endtask

    // Count edges until each pin reaches tgt; compare with the expected latency.
    task automatic measure(input logic [NP-1:0] tgt, input int start, input int ovr, input string req);
        int first [NP];
        for (int p = 0; p < NP; p++) first[p] = -1;
        for (int n = start; n <= MAXW; n++) begin
            @(posedge clk); @(negedge clk);
            for (int p = 0; p < NP; p++)
                if (first[p] < 0 && pin_filt[p] == tgt[p]) first[p] = n;
        end
        for (int p = 0; p < NP; p++) begin
            int e;
            e = (ovr >= 0) ? ovr : exp_lat(p);
            check(first[p] == e, $sformatf("%s pin%0d", req, p), first[p], e);
        end
    endtask

    task automatic sweep(input logic [NP-1:0] v, input string req);
        pin_raw = v;
        measure(v, 1, -1, req);
    endtask

    initial begin
        fork
            begin
                #1000000;
                errors++;
                checks++;
                $display("FAIL watchdog: actual=timeout expected=finish");
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        join_none

        // R1: reset clears synchronizers and configuration
        pin_raw = '1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(pin_filt == '0, "R1 reset output", pin_filt, 0);
        rst_n = 1'b1;
        @(posedge clk); @(negedge clk);
        check(pin_filt == '0, "R1 one edge after reset", pin_filt, 0);
        @(posedge clk); @(negedge clk);
        check(pin_filt == '1, "R2 bypass after two edges", pin_filt, 32'hFFFFFFFF);
        // R1/R2: all pins in bypass after reset
        sweep('0, "R2 bypass fall");

        // R3 R4 R10: mode = pin index mod 4
        wr(3'd0, 32'd3); wr(3'd1, 32'd5); wr(3'd2, 32'd8);
        wr(3'd3, 32'hCCCCCCCC); wr(3'd4, 32'hAAAAAAAA);
        sweep('1, "R4 R10 mixed rise");
        sweep('0, "R8 mixed fall");

        // R3: high bit alone selects period 2, low bit alone period 1
        wr(3'd3, 32'hFFFF0000); wr(3'd4, 32'h0000FFFF);
        sweep('1, "R3 select order");

        // R6: zero period acts as bypass
        wr(3'd1, 32'd0);
        sweep('0, "R6 zero period");

        // R9: unused addresses are ignored
        wr(3'd5, '1); wr(3'd6, '1); wr(3'd7, '1);
        sweep('1, "R9 unused writes");

        // R5: short dip restarts the count
        wr(3'd3, '1); wr(3'd4, '1);
        sweep('0, "R4 period3 fall");
        pin_raw = '1;
        for (int k = 0; k < 5; k++) begin
            @(posedge clk); @(negedge clk);
            check(pin_filt == '0, "R5 held during count", pin_filt, 0);
        end
        pin_raw = '0;
        @(posedge clk); @(negedge clk);
        check(pin_filt == '0, "R5 held during dip", pin_filt, 0);
        sweep('1, "R5 restart after dip");

        // R7: period rewrite mid-count clears the count
        sweep('0, "R8 period3 fall");
        pin_raw = '1;
        for (int k = 0; k < 5; k++) begin
            @(posedge clk); @(negedge clk);
            check(pin_filt == '0, "R7 held before rewrite", pin_filt, 0);
        end
        wr(3'd2, 32'd6);
        measure('1, 2, 8, "R7 count cleared");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule